// File: doc/BRIEF.md
# Multi-Source Interrupt Request Aggregator

This block gathers up to eight peripheral interrupt sources into a single interrupt request flag. Each source has a status bit and an enable bit. Peripherals set a status bit with a one-cycle event pulse. Software clears status bits by writing 0 to them. The request flag is not a stored edge. It is recomputed every cycle as the OR, over all sources, of status AND enable. Because of this, a request that nobody acknowledged disappears as soon as its source is cleared or disabled.

Software reaches three registers through a small write/read port: the status register, the enable register and a control register. The control register holds a 3-bit priority level and the live request flag. Writing 0 to the flag cannot clear it for good. It only holds the flag low for a short window of five clock cycles. After that the flag again shows the combined request state. The CPU acknowledge input clears nothing. The block signals that it wants service only when the flag is 1 and its priority level is above the processor's current level.

Top module: `irq_aggregator`

## Requirements
- R1: Outside a forced-low window, the request flag (control bit 3) reads 1 whenever at least one source has both its status bit and its enable bit at 1. A further source becoming pending while the flag is 1 leaves it at 1.
- R2: The request flag reads 0 whenever no source has both its status bit and its enable bit at 1, even if the request was never acknowledged.
- R3: A control write with bit 3 at 0 holds the flag at 0 for exactly five clock cycles after the write edge. After that the flag again follows R1/R2.
- R4: A second control write with bit 3 at 0 during the window restarts it, so the flag stays 0 for five cycles after the later write.
- R5: A control write with bit 3 at 1 has no effect on the flag. It neither sets the flag nor ends a running window.
- R6: Asserting the acknowledge input clears no status bit and does not lower the flag.
- R7: An event pulse on source i sets status bit i at the next edge. A status write clears each bit written 0 and leaves each bit written 1 unchanged. If a clear and an event hit the same bit in the same cycle, the bit ends up 1.
- R8: The enable register is read/write. Each bit i gates source i.
- R9: The take output is 1 exactly when the flag is 1 and the 3-bit priority level is strictly greater than the processor level input. A level of 0 never produces a take.
- R10: Register map: address 0 is status, 1 is enable, 2 is control. Control reads as {4'b0, flag, level[2:0]}, and level is written from bits [2:0]. Address 3 reads 0 and ignores writes.
- R11: After reset, status, enable, level and flag read 0 and take is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt_i | input | 8 | One-cycle event pulses, one per source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i (combinational) |
| cpu_ack_i | input | 1 | CPU acknowledge, has no effect on state |
| cpu_level_i | input | 3 | Processor's current priority level |
| irq_take_o | output | 1 | Request flag set and level above processor level |

## Verification
The hardest case to reach from the ports is the forced-low window overlapping other activity. Examples are a second clear arriving mid-window, a write of 1 landing inside the window, and sources being cleared or disabled so that the flag must come back low rather than high when the window ends. Directed sequences place each of these at chosen cycle offsets and count the low cycles exactly. Seeded random traffic, with frequent control writes, then mixes windows with event/clear collisions and acknowledges, and a bench model derived from the requirements checks the result.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_src_status.sv
module irq_src_status #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] stat_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // set dominates a same-cycle clear
    always_comb begin
      stat_d[i] = stat_q[i];
      if (clr_i[i]) stat_d[i] = 1'b0;
      if (set_i[i]) stat_d[i] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= stat_d[i];
    end

    a_r7_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_o[i]);
    a_r7_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !stat_o[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl #(
  parameter int PRIO_W = 3,
  parameter int HOLD   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              lvl_we_i,
  input  logic [PRIO_W-1:0] lvl_wdata_i,
  input  logic              flag_clr_i,
  output logic [PRIO_W-1:0] lvl_o,
  output logic              flag_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [PRIO_W-1:0] lvl_q, lvl_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              masked;

  always_comb begin
    lvl_d = lvl_q;
    if (lvl_we_i) lvl_d = lvl_wdata_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (flag_clr_i)        cnt_d = HOLD_V;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign masked = (cnt_q != '0);
  assign flag_o = pend_i && !masked;
  assign lvl_o  = lvl_q;

  a_r3_low_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !flag_o);
  a_r3_window_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && !flag_clr_i) |=> (flag_o == pend_i));
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
  parameter int PRIO_W = 3
) (
  input  logic              flag_i,
  input  logic [PRIO_W-1:0] lvl_i,
  input  logic [PRIO_W-1:0] cpu_lvl_i,
  output logic              take_o
);
  always_comb begin
    take_o = flag_i && (lvl_i > cpu_lvl_i);
  end

  always_comb begin
    if (lvl_i == '0) a_r9_level_zero_off: assert (!take_o);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int HOLD    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [NUM_SRC-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] bus_rdata_o,
  input  logic               cpu_ack_i,
  input  logic [PRIO_W-1:0]  cpu_level_i,
  output logic               irq_take_o
);
  import irq_agg_pkg::*;

  localparam int DATA_W   = NUM_SRC;
  localparam int FLAG_BIT = PRIO_W;
  localparam int PAD_W    = DATA_W - PRIO_W - 1;

  logic               rst_n;
  reg_sel_e           sel;
  logic               wr_stat, wr_en, wr_ctrl;
  logic [DATA_W-1:0]  stat, en_q, en_d, clr_mask;
  logic               pend, flag, flag_clr;
  logic [PRIO_W-1:0]  lvl;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // register decode
  always_comb begin
    sel      = reg_sel_e'(bus_addr_i);
    wr_stat  = bus_we_i && (sel == SEL_STATUS);
    wr_en    = bus_we_i && (sel == SEL_ENABLE);
    wr_ctrl  = bus_we_i && (sel == SEL_CONTROL);
    clr_mask = wr_stat ? ~bus_wdata_i : '0;
    flag_clr = wr_ctrl && !bus_wdata_i[FLAG_BIT];
  end

  irq_src_status #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (src_evt_i),
    .clr_i  (clr_mask),
    .stat_o (stat)
  );

  // enable register
  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign pend = |(stat & en_q);

  irq_req_ctrl #(.PRIO_W(PRIO_W), .HOLD(HOLD)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .pend_i      (pend),
    .lvl_we_i    (wr_ctrl),
    .lvl_wdata_i (bus_wdata_i[PRIO_W-1:0]),
    .flag_clr_i  (flag_clr),
    .lvl_o       (lvl),
    .flag_o      (flag)
  );

  irq_prio_gate #(.PRIO_W(PRIO_W)) u_gate (
    .flag_i    (flag),
    .lvl_i     (lvl),
    .cpu_lvl_i (cpu_level_i),
    .take_o    (irq_take_o)
  );

  // read mux
  always_comb begin
    unique case (sel)
      SEL_STATUS:  bus_rdata_o = stat;
      SEL_ENABLE:  bus_rdata_o = en_q;
      SEL_CONTROL: bus_rdata_o = {{PAD_W{1'b0}}, flag, lvl};
      default:     bus_rdata_o = '0;
    endcase
  end

  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|(stat & en_q)) |-> !flag);
  a_r6_ack_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cpu_ack_i && !wr_stat) |=> ((stat & $past(stat)) == $past(stat)));
  a_r8_enable_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en |=> (en_q == $past(bus_wdata_i)));
  a_r5_one_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!flag && !pend && !flag_clr) |=> (!flag || pend));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int  N   = 8;
  localparam time CLK = 4ns;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [N-1:0] evt;
  logic         we;
  logic [1:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         ack;
  logic [2:0]   cpu_lvl;
  logic         take;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [N-1:0] m_stat, m_en;
  logic [2:0]   m_lvl;
  int           m_cnt;
  logic [N-1:0] last_rdata;

  always #(CLK/2) clk = ~clk;

  irq_aggregator uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .src_evt_i   (evt),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .cpu_ack_i   (ack),
    .cpu_level_i (cpu_lvl),
    .irq_take_o  (take)
  );

  function automatic logic exp_flag();
    return (|(m_stat & m_en)) && (m_cnt == 0);
  endfunction

  function automatic logic [N-1:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return m_stat;
      2'd1:    return m_en;
      2'd2:    return {4'b0, exp_flag(), m_lvl};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_take(input logic [2:0] cl);
    return exp_flag() && (m_lvl > cl);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic w, input logic [1:0] a,
                     input logic [N-1:0] d, input logic [N-1:0] e,
                     input logic k, input logic [2:0] cl);
    @(negedge clk);
    we = w; addr = a; wdata = d; evt = e; ack = k; cpu_lvl = cl;
    #1;
    last_rdata = rdata;
    chk({tag, " rdata"}, 32'(rdata), 32'(exp_rdata(a)));
    chk({tag, " take"},  32'(take),  32'(exp_take(cl)));
    @(posedge clk);
    // model update from the requirements
    if (w && a == 2'd0) m_stat = m_stat & d;
    m_stat = m_stat | e;
    if (w && a == 2'd1) m_en = d;
    if (w && a == 2'd2) begin
      m_lvl = d[2:0];
      if (!d[3])          m_cnt = 5;
      else if (m_cnt > 0) m_cnt--;
    end else if (m_cnt > 0) m_cnt--;
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    cyc(tag, 1'b0, a, '0, '0, 1'b0, 3'd0);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'd20240611));
    m_stat = '0; m_en = '0; m_lvl = '0; m_cnt = 0;
    rst_ni = 1'b0; we = 0; addr = 0; wdata = 0; evt = 0; ack = 0; cpu_lvl = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    rd("R11", 2'd0); rd("R11", 2'd1); rd("R11", 2'd2);
    chk("R11 control", 32'(last_rdata), 32'h0);

    // R10 map, level write, address 3
    cyc("R10", 1, 2'd2, 8'h0E, 0, 0, 0);   // level 6, bit3=1
    cyc("R10", 1, 2'd3, 8'hFF, 0, 0, 0);
    rd("R10", 2'd3);
    chk("R10 addr3", 32'(last_rdata), 32'h0);
    rd("R10", 2'd2);
    chk("R10 level", 32'(last_rdata), 32'h06);

    // R8 enable, R7 event sets, R1 flag rises
    cyc("R8", 1, 2'd1, 8'h05, 0, 0, 0);
    rd("R8", 2'd1);
    chk("R8 enable", 32'(last_rdata), 32'h05);
    cyc("R7", 0, 2'd2, 0, 8'h02, 0, 0);    // disabled source
    rd("R2", 2'd2);
    chk("R2 disabled pend", 32'(last_rdata[3]), 32'h0);
    cyc("R7", 0, 2'd2, 0, 8'h01, 0, 0);
    rd("R1", 2'd2);
    chk("R1 flag set", 32'(last_rdata[3]), 32'h1);
    chk("R9 take lvl6>0", 32'(take), 32'h1);
    cyc("R1", 0, 2'd2, 0, 8'h04, 0, 0);    // more pending, flag stays
    rd("R1", 2'd2);
    chk("R1 stays", 32'(last_rdata[3]), 32'h1);
    cyc("R9", 0, 2'd2, 0, 0, 0, 3'd6);
    chk("R9 equal level", 32'(take), 32'h0);

    // R6 acknowledge clears nothing
    cyc("R6", 0, 2'd0, 0, 0, 1, 0);
    rd("R6", 2'd0);
    chk("R6 status", 32'(last_rdata), 32'h07);
    rd("R6", 2'd2);
    chk("R6 flag", 32'(last_rdata[3]), 32'h1);

    // R3 exact window
    cyc("R3", 1, 2'd2, 8'h06, 0, 0, 0);
    lows = 0;
    for (int i = 0; i < 7; i++) begin
      rd("R3", 2'd2);
      if (!last_rdata[3]) lows++;
    end
    chk("R3 low cycles", 32'(lows), 32'd5);

    // R4 restart and R5 write-1 inside window
    cyc("R4", 1, 2'd2, 8'h06, 0, 0, 0);
    rd("R4", 2'd2); rd("R4", 2'd2);
    cyc("R5", 1, 2'd2, 8'h0E, 0, 0, 0);   // write 1 mid-window
    cyc("R4", 1, 2'd2, 8'h06, 0, 0, 0);
    lows = 0;
    for (int i = 0; i < 7; i++) begin
      rd("R4", 2'd2);
      if (!last_rdata[3]) lows++;
    end
    chk("R4 restarted low cycles", 32'(lows), 32'd5);

    // R7 clear semantics and collision
    cyc("R7", 1, 2'd0, 8'hFE, 8'h00, 0, 0); // clear bit0
    rd("R7", 2'd0);
    chk("R7 clear bit0", 32'(last_rdata), 32'h06);
    cyc("R7", 1, 2'd0, 8'h00, 8'h04, 0, 0); // clear all, event bit2
    rd("R7", 2'd0);
    chk("R7 set wins", 32'(last_rdata), 32'h04);

    // R2 not retained; R5 write 1 with nothing pending
    cyc("R2", 1, 2'd0, 8'h00, 0, 0, 0);
    rd("R2", 2'd2);
    chk("R2 dropped", 32'(last_rdata[3]), 32'h0);
    cyc("R5", 1, 2'd2, 8'h0E, 0, 0, 0);
    rd("R5", 2'd2);
    chk("R5 no set", 32'(last_rdata[3]), 32'h0);

    // R9 level zero
    cyc("R9", 1, 2'd2, 8'h08, 8'h01, 0, 0);
    rd("R9", 2'd2);
    chk("R9 flag on lvl0", 32'(last_rdata[3]), 32'h1);
    chk("R9 level zero", 32'(take), 32'h0);

    // R3 window ending low when source cleared meanwhile
    cyc("R3", 1, 2'd2, 8'h05, 0, 0, 0);
    cyc("R3", 1, 2'd0, 8'h00, 0, 0, 0);
    for (int i = 0; i < 6; i++) rd("R3", 2'd2);
    chk("R3 returns low", 32'(last_rdata[3]), 32'h0);

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] e;
      logic w;
      logic [1:0] a;
      e = N'($urandom) & N'($urandom) & N'($urandom);
      w = ($urandom_range(0, 3) == 0);
      a = 2'($urandom);
      cyc("R1", w, a, N'($urandom), e, 1'($urandom), 3'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule